// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block sits at the home node of one region of distributed shared memory. For every block of the region it keeps a directory entry and a copy of the block's data. The entry holds one of three states (Uncached, Shared, Exclusive) and a presence vector with one bit per processor. Caches send it read misses and write misses on a request stream and return block data on a separate write-back stream. The controller answers with point-to-point messages on one outgoing stream: invalidate, fetch, fetch-and-invalidate, and data reply. It does not broadcast, because each message goes to one processor.

The controller works on one miss at a time. If a miss hits a block that another cache owns, the controller sends the owner a fetch and waits for the owner's write-back. During that wait the request stream is held, but the write-back stream stays open, so the answer can always arrive. When a Shared block takes a write miss, the controller sends the invalidates one at a time, from the lowest processor number to the highest.

All three streams use valid/ready. A sender holds valid and its fields steady until the cycle in which ready is also high; that cycle completes the transfer. The controller keeps `msg_valid` and every `msg_*` field steady while `msg_ready` is low. The controller can lower `req_ready` and `wb_ready` in any cycle. It never withdraws a message it has presented.

Top module: `home_dir_ctrl`

## Requirements
- R1: Reset effects, with the block idle:
  - every entry becomes Uncached with an empty presence vector;
  - all block data becomes zero;
  - `req_ready` and `wb_ready` are high;
  - `msg_valid` is low.
- R2: A read miss (`req_wr`=0) from P to an Uncached block:
  - sends P a data reply (`msg_kind`=3) with the block's stored data;
  - leaves the block Shared with presence {P}.
- R3: A write miss (`req_wr`=1) from P to an Uncached block:
  - sends P a data reply;
  - leaves the block Exclusive with owner P.
- R4: A read miss from P to a Shared block adds P to the presence vector, keeps the block Shared, and sends P a data reply.
- R5: A write miss from P to a Shared block:
  - sends an invalidate (`msg_kind`=0) to every present processor other than P, one message each, in ascending processor order;
  - then makes the block Exclusive with owner P;
  - then sends P a data reply.
- R6: A read miss from P to a block owned by Q:
  - sends a fetch (`msg_kind`=1) to Q and waits for Q's write-back of that block;
  - stores the returned data;
  - leaves the block Shared with presence {Q, P};
  - sends P a data reply that carries the returned data.
- R7: A write miss from P to a block owned by Q:
  - sends a fetch-and-invalidate (`msg_kind`=2) to Q and waits for Q's write-back;
  - stores the returned data;
  - makes P the sole owner;
  - sends P a data reply that carries the returned data.
- R8: A write-back from the owner of an Exclusive block stores the data, makes the block Uncached with empty presence, and sends no message.
- R9: A write-back changes neither data nor directory and sends no message in any of these cases:
  - the block is Uncached;
  - the block is Shared;
  - the sender is not the owner.
- R10: While the controller waits for an owner's write-back:
  - `req_ready` stays low;
  - `wb_ready` stays high;
  - a held request is accepted only after the pending reply completes.
- R11: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_kind`, `msg_dst`, `msg_addr` and `msg_data` hold their values.
- R12: After a request is accepted, `req_ready` stays low until that request's data reply completes its transfer.
- R13: When a write-back and a request are both valid while the block is idle, the write-back is taken first (`wb_ready` high, `req_ready` low). The request then sees the directory as the write-back left it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Controller takes the request this cycle |
| req_wr | input | 1 | 1 = write miss, 0 = read miss |
| req_src | input | $clog2(NPROC) | Requesting processor |
| req_addr | input | $clog2(NBLK) | Block index |
| wb_valid | input | 1 | Write-back present |
| wb_ready | output | 1 | Controller takes the write-back this cycle |
| wb_src | input | $clog2(NPROC) | Processor returning the block |
| wb_addr | input | $clog2(NBLK) | Block index |
| wb_data | input | DW | Returned block data |
| msg_valid | output | 1 | Outgoing message present |
| msg_ready | input | 1 | Receiver takes the message this cycle |
| msg_kind | output | 2 | 0 invalidate, 1 fetch, 2 fetch-and-invalidate, 3 data reply |
| msg_dst | output | $clog2(NPROC) | Destination processor |
| msg_addr | output | $clog2(NBLK) | Block index |
| msg_data | output | DW | Block data for a reply, zero otherwise |

## Verification
Two functions can meet in the same cycle:
- a write-back on its own stream;
- a miss on the request stream.

The bench provokes the meeting in two ways:
- It drives an owner's voluntary write-back and another processor's read miss to the same Exclusive block on one clock edge. It checks that only the write-back is taken. It then checks that the read miss is answered directly, with no fetch, and that the reply carries the written-back data.
- It holds a read miss on the request stream while a fetch is outstanding. First it sends a write-back from a processor that does not own the block, then the owner's real write-back. It checks that the request stays blocked, that the stray write-back leaves the data unchanged, and that the held request is served after the reply.

// File: rtl/hdc_pkg.sv
package hdc_pkg;

  typedef enum logic [1:0] {
    DS_UNCACHED = 2'd0,
    DS_SHARED   = 2'd1,
    DS_EXCL     = 2'd2
  } dir_state_e;

  typedef enum logic [1:0] {
    MK_INVAL       = 2'd0,
    MK_FETCH       = 2'd1,
    MK_FETCH_INVAL = 2'd2,
    MK_DATA        = 2'd3
  } msg_kind_e;

  typedef enum logic [2:0] {
    CS_IDLE,
    CS_EXEC,
    CS_INVAL,
    CS_FETCH,
    CS_WAIT,
    CS_REPLY
  } ctrl_state_e;

endpackage

// File: rtl/hdc_lowbit.sv
module hdc_lowbit #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic [N-1:0]  first_oh,
  output logic [IW-1:0] first_idx
);

  // seen[i] is set when any bit below i is set
  logic [N-1:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign first_oh[i] = vec[i] & ~seen[i];
    if (i < N - 1) begin : g_chain
      assign seen[i+1] = seen[i] | vec[i];
    end
  end

  always_comb begin
    first_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) first_idx = IW'(i);
    end
  end

  // R5: at most one pick, and only from a set bit
  always_comb begin
    if (!$isunknown(vec)) begin
      a_lowbit_single_r5: assert ($onehot0(first_oh) && ((first_oh & ~vec) == '0));
    end
  end

endmodule

// File: rtl/hdc_dir_table.sv
module hdc_dir_table
  import hdc_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NBLK  = 8,
  localparam int AW = $clog2(NBLK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    ra_addr,
  output dir_state_e       ra_state,
  output logic [NPROC-1:0] ra_sharers,
  input  logic [AW-1:0]    rb_addr,
  output dir_state_e       rb_state,
  output logic [NPROC-1:0] rb_sharers,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  dir_state_e       wstate,
  input  logic [NPROC-1:0] wsharers
);

  dir_state_e       st_q [NBLK];
  logic [NPROC-1:0] sh_q [NBLK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBLK; i++) begin
        st_q[i] <= DS_UNCACHED;
        sh_q[i] <= '0;
      end
    end else if (we) begin
      st_q[waddr] <= wstate;
      sh_q[waddr] <= wsharers;
    end
  end

  assign ra_state   = st_q[ra_addr];
  assign ra_sharers = sh_q[ra_addr];
  assign rb_state   = st_q[rb_addr];
  assign rb_sharers = sh_q[rb_addr];

  // Entry invariants kept by every transition
  for (genvar g = 0; g < NBLK; g++) begin : g_chk
    p_excl_single_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[g] == DS_EXCL) |-> ($countones(sh_q[g]) == 1));
    p_uncached_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[g] == DS_UNCACHED) |-> (sh_q[g] == '0));
    p_shared_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[g] == DS_SHARED) |-> (sh_q[g] != '0));
  end

endmodule

// File: rtl/hdc_block_mem.sv
module hdc_block_mem #(
  parameter int NBLK = 8,
  parameter int DW   = 16,
  localparam int AW = $clog2(NBLK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata
);

  logic [DW-1:0] mem_q [NBLK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBLK; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/home_dir_ctrl.sv
module home_dir_ctrl
  import hdc_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NBLK  = 8,
  parameter int DW    = 16,
  localparam int PW = $clog2(NPROC),
  localparam int AW = $clog2(NBLK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_wr,
  input  logic [PW-1:0] req_src,
  input  logic [AW-1:0] req_addr,
  input  logic          wb_valid,
  output logic          wb_ready,
  input  logic [PW-1:0] wb_src,
  input  logic [AW-1:0] wb_addr,
  input  logic [DW-1:0] wb_data,
  output logic          msg_valid,
  input  logic          msg_ready,
  output logic [1:0]    msg_kind,
  output logic [PW-1:0] msg_dst,
  output logic [AW-1:0] msg_addr,
  output logic [DW-1:0] msg_data
);

  ctrl_state_e      cs_q, cs_d;
  logic             cur_wr_q;
  logic [PW-1:0]    cur_src_q;
  logic [AW-1:0]    cur_addr_q;
  logic [NPROC-1:0] inv_q, inv_d;

  dir_state_e       a_state, b_state, dir_wstate;
  logic [NPROC-1:0] a_sh, b_sh, dir_wsh;
  logic             dir_we;
  logic [AW-1:0]    dir_waddr;
  logic             mem_we;
  logic [DW-1:0]    mem_rdata;

  logic [NPROC-1:0] src_oh, own_oh, inv_oh;
  logic [PW-1:0]    own_idx, inv_idx;
  logic             wb_hit;

  hdc_dir_table #(.NPROC(NPROC), .NBLK(NBLK)) u_dir (
    .clk(clk), .rst_n(rst_n),
    .ra_addr(cur_addr_q), .ra_state(a_state), .ra_sharers(a_sh),
    .rb_addr(wb_addr), .rb_state(b_state), .rb_sharers(b_sh),
    .we(dir_we), .waddr(dir_waddr), .wstate(dir_wstate), .wsharers(dir_wsh)
  );

  hdc_block_mem #(.NBLK(NBLK), .DW(DW)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .raddr(cur_addr_q), .rdata(mem_rdata),
    .we(mem_we), .waddr(wb_addr), .wdata(wb_data)
  );

  hdc_lowbit #(.N(NPROC)) u_owner (.vec(a_sh),  .first_oh(own_oh), .first_idx(own_idx));
  hdc_lowbit #(.N(NPROC)) u_inval (.vec(inv_q), .first_oh(inv_oh), .first_idx(inv_idx));

  assign src_oh = {{(NPROC-1){1'b0}}, 1'b1} << cur_src_q;
  // write-back from the current owner of an Exclusive block
  assign wb_hit = (b_state == DS_EXCL) && b_sh[wb_src];

  always_comb begin
    cs_d       = cs_q;
    inv_d      = inv_q;
    req_ready  = 1'b0;
    wb_ready   = 1'b0;
    msg_valid  = 1'b0;
    msg_kind   = MK_DATA;
    msg_dst    = cur_src_q;
    msg_addr   = cur_addr_q;
    msg_data   = '0;
    dir_we     = 1'b0;
    dir_waddr  = cur_addr_q;
    dir_wstate = DS_UNCACHED;
    dir_wsh    = '0;
    mem_we     = 1'b0;
    unique case (cs_q)
      CS_IDLE: begin
        wb_ready  = 1'b1;
        req_ready = !wb_valid;
        if (wb_valid) begin
          if (wb_hit) begin
            mem_we    = 1'b1;
            dir_we    = 1'b1;
            dir_waddr = wb_addr;
          end
        end else if (req_valid) begin
          cs_d = CS_EXEC;
        end
      end
      CS_EXEC: begin
        unique case (a_state)
          DS_UNCACHED: begin
            dir_we     = 1'b1;
            dir_wstate = cur_wr_q ? DS_EXCL : DS_SHARED;
            dir_wsh    = src_oh;
            cs_d       = CS_REPLY;
          end
          DS_SHARED: begin
            if (!cur_wr_q) begin
              dir_we     = 1'b1;
              dir_wstate = DS_SHARED;
              dir_wsh    = a_sh | src_oh;
              cs_d       = CS_REPLY;
            end else if ((a_sh & ~src_oh) != '0) begin
              inv_d = a_sh & ~src_oh;
              cs_d  = CS_INVAL;
            end else begin
              dir_we     = 1'b1;
              dir_wstate = DS_EXCL;
              dir_wsh    = src_oh;
              cs_d       = CS_REPLY;
            end
          end
          default: cs_d = CS_FETCH;
        endcase
      end
      CS_INVAL: begin
        msg_valid = 1'b1;
        msg_kind  = MK_INVAL;
        msg_dst   = inv_idx;
        if (msg_ready) begin
          inv_d = inv_q & ~inv_oh;
          if (inv_d == '0) begin
            dir_we     = 1'b1;
            dir_wstate = DS_EXCL;
            dir_wsh    = src_oh;
            cs_d       = CS_REPLY;
          end
        end
      end
      CS_FETCH: begin
        msg_valid = 1'b1;
        msg_kind  = cur_wr_q ? MK_FETCH_INVAL : MK_FETCH;
        msg_dst   = own_idx;
        if (msg_ready) cs_d = CS_WAIT;
      end
      CS_WAIT: begin
        wb_ready = 1'b1;
        if (wb_valid) begin
          if ((wb_addr == cur_addr_q) && own_oh[wb_src]) begin
            mem_we     = 1'b1;
            dir_we     = 1'b1;
            dir_wstate = cur_wr_q ? DS_EXCL : DS_SHARED;
            dir_wsh    = cur_wr_q ? src_oh : (a_sh | src_oh);
            cs_d       = CS_REPLY;
          end else if (wb_hit) begin
            mem_we    = 1'b1;
            dir_we    = 1'b1;
            dir_waddr = wb_addr;
          end
        end
      end
      CS_REPLY: begin
        msg_valid = 1'b1;
        msg_kind  = MK_DATA;
        msg_data  = mem_rdata;
        if (msg_ready) cs_d = CS_IDLE;
      end
      default: cs_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q       <= CS_IDLE;
      inv_q      <= '0;
      cur_wr_q   <= 1'b0;
      cur_src_q  <= '0;
      cur_addr_q <= '0;
    end else begin
      cs_q  <= cs_d;
      inv_q <= inv_d;
      if (req_valid && req_ready) begin
        cur_wr_q   <= req_wr;
        cur_src_q  <= req_src;
        cur_addr_q <= req_addr;
      end
    end
  end

  p_msg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable({msg_kind, msg_dst, msg_addr, msg_data})));

  p_single_txn_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_fetch_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready && (msg_kind == MK_FETCH || msg_kind == MK_FETCH_INVAL)) |=>
      (!req_ready && wb_ready));

  p_inv_ascending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready && msg_kind == MK_INVAL) ##1 (msg_valid && msg_kind == MK_INVAL)
      |-> (msg_dst > $past(msg_dst)));

  p_wb_first_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> !wb_valid);

endmodule

// File: tb/home_dir_ctrl_test.sv
module home_dir_ctrl_test;

  localparam int NP = 4;
  localparam int NB = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_wr = 1'b0;
  logic [1:0] req_src = '0;
  logic [2:0] req_addr = '0;
  logic req_ready, wb_ready, msg_valid;
  logic wb_valid = 1'b0;
  logic [1:0] wb_src = '0;
  logic [2:0] wb_addr = '0;
  logic [DW-1:0] wb_data = '0;
  logic msg_ready = 1'b0;
  logic [1:0] msg_kind, msg_dst;
  logic [2:0] msg_addr;
  logic [DW-1:0] msg_data;

  always #10 clk = ~clk;

  home_dir_ctrl #(.NPROC(NP), .NBLK(NB), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_wr(req_wr),
    .req_src(req_src), .req_addr(req_addr),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_src(wb_src),
    .wb_addr(wb_addr), .wb_data(wb_data),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
    .msg_dst(msg_dst), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  int n_checks = 0;
  int n_fails  = 0;
  int cyc = 0;

  // Reference directory: 0 uncached, 1 shared, 2 exclusive
  int            m_st  [NB];
  logic [NP-1:0] m_sh  [NB];
  logic [DW-1:0] m_mem [NB];

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_checks++;
      n_fails++;
      $display("FAIL R12 watchdog: actual hung expected done");
      report();
      $finish;
    end
  end

  task automatic take_msg(input int bp, input int ek, input int edst, input int eaddr,
                          input logic [DW-1:0] edata, input bit cmp_data, input string tag);
    logic [1:0] k0, d0;
    logic [2:0] a0;
    logic [DW-1:0] x0;
    @(negedge clk);
    while (!msg_valid) @(negedge clk);
    k0 = msg_kind; d0 = msg_dst; a0 = msg_addr; x0 = msg_data;
    for (int i = 0; i < bp; i++) begin
      @(negedge clk);
      chk(msg_valid && msg_kind == k0 && msg_dst == d0 && msg_addr == a0 && msg_data == x0,
          "R11", "held message", {msg_kind, msg_dst, msg_addr}, {k0, d0, a0});
    end
    chk(k0 == ek, tag, "kind", k0, ek);
    chk(d0 == edst, tag, "dst", d0, edst);
    chk(a0 == eaddr, tag, "addr", a0, eaddr);
    if (cmp_data) chk(x0 == edata, tag, "data", x0, edata);
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  task automatic wait_req_accept();
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 1'b0;
    chk(!req_ready, "R12", "ready after accept", req_ready, 0);
  endtask

  task automatic send_req(input bit wr, input int src, input int addr);
    @(negedge clk);
    req_valid = 1'b1; req_wr = wr; req_src = 2'(src); req_addr = 3'(addr);
    wait_req_accept();
  endtask

  task automatic send_wb(input int src, input int addr, input logic [DW-1:0] d);
    @(negedge clk);
    wb_valid = 1'b1; wb_src = 2'(src); wb_addr = 3'(addr); wb_data = d;
    #1;
    while (!wb_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    wb_valid = 1'b0;
  endtask

  task automatic expect_resp(input bit wr, input int src, input int addr,
                             input logic [DW-1:0] fdata, input int bp);
    logic [NP-1:0] soh;
    int owner;
    soh = NP'(1) << src;
    if (m_st[addr] == 0) begin
      take_msg(bp, 3, src, addr, m_mem[addr], 1, wr ? "R3" : "R2");
      m_st[addr] = wr ? 2 : 1;
      m_sh[addr] = soh;
    end else if (m_st[addr] == 1) begin
      if (!wr) begin
        take_msg(bp, 3, src, addr, m_mem[addr], 1, "R4");
        m_sh[addr] = m_sh[addr] | soh;
      end else begin
        for (int p = 0; p < NP; p++)
          if (m_sh[addr][p] && p != src) take_msg(bp, 0, p, addr, '0, 0, "R5");
        take_msg(bp, 3, src, addr, m_mem[addr], 1, "R5");
        m_st[addr] = 2;
        m_sh[addr] = soh;
      end
    end else begin
      owner = 0;
      for (int p = NP - 1; p >= 0; p--) if (m_sh[addr][p]) owner = p;
      take_msg(bp, wr ? 2 : 1, owner, addr, '0, 0, wr ? "R7" : "R6");
      send_wb(owner, addr, fdata);
      m_mem[addr] = fdata;
      take_msg(bp, 3, src, addr, fdata, 1, wr ? "R7" : "R6");
      if (wr) m_sh[addr] = soh;
      else begin m_st[addr] = 1; m_sh[addr] = m_sh[addr] | soh; end
    end
  endtask

  task automatic access(input bit wr, input int src, input int addr,
                        input logic [DW-1:0] fdata, input int bp);
    send_req(wr, src, addr);
    expect_resp(wr, src, addr, fdata, bp);
  endtask

  task automatic ref_wb(input int src, input int addr, input logic [DW-1:0] d);
    string tag;
    send_wb(src, addr, d);
    if (m_st[addr] == 2 && m_sh[addr][src]) begin
      tag = "R8";
      m_mem[addr] = d; m_st[addr] = 0; m_sh[addr] = '0;
    end else tag = "R9";
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk(!msg_valid, tag, "no message after write-back", msg_valid, 0);
    end
  endtask

  logic [15:0] lfsr = 16'hACE1;

  initial begin
    for (int i = 0; i < NB; i++) begin m_st[i] = 0; m_sh[i] = '0; m_mem[i] = '0; end
    repeat (3) @(negedge clk);
    chk(req_ready && wb_ready && !msg_valid, "R1", "ports in reset",
        {req_ready, wb_ready, msg_valid}, 3'b110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && wb_ready && !msg_valid, "R1", "ports after reset",
        {req_ready, wb_ready, msg_valid}, 3'b110);

    // R1 R2 R4: every processor reads every block; data starts at zero
    for (int a = 0; a < NB; a++)
      for (int s = 0; s < NP; s++) access(0, s, a, '0, s % 2);
    // R5: one writer per block invalidates the other three
    for (int a = 0; a < NB; a++) access(1, a % NP, a, '0, a % 3);
    // R7: a second writer steals ownership
    for (int a = 0; a < NB; a++) access(1, (a + 2) % NP, a, 16'hB000 + 16'(a * 3), 1);
    // R6: a reader forces the owner to share
    for (int a = 0; a < NB; a++) access(0, (a + 1) % NP, a, 16'hA000 + 16'(a), 0);
    // R9: write-back to a Shared block is ignored
    for (int a = 0; a < NB; a++) ref_wb((a + 1) % NP, a, 16'hDEAD);
    for (int a = 0; a < NB; a++) access(0, 3, a, '0, 0);

    // R8: owner eviction, then R9 on the Uncached block, then a direct reply
    access(1, 1, 0, '0, 0);
    ref_wb(1, 0, 16'h0C0F);
    ref_wb(1, 0, 16'hBAD0);
    access(0, 2, 0, '0, 1);
    // R9: a write-back from a processor that does not own the block
    access(1, 3, 2, '0, 0);
    ref_wb(0, 2, 16'hBAD1);
    access(0, 1, 2, 16'h2222, 0);

    // R10: request held during a fetch, with a stray write-back first
    access(1, 0, 1, '0, 0);
    send_req(0, 1, 1);
    take_msg(0, 1, 0, 1, '0, 0, "R10");
    @(negedge clk);
    req_valid = 1'b1; req_wr = 1'b0; req_src = 2'd2; req_addr = 3'd2;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      chk(!req_ready && wb_ready, "R10", "ready while waiting", {req_ready, wb_ready}, 2'b01);
    end
    send_wb(3, 1, 16'hDEAD);
    @(negedge clk);
    chk(!msg_valid && !req_ready, "R9", "stray write-back during wait", msg_valid, 0);
    send_wb(0, 1, 16'h1234);
    m_mem[1] = 16'h1234; m_st[1] = 1; m_sh[1] = 4'b0011;
    take_msg(0, 3, 1, 1, 16'h1234, 1, "R10");
    wait_req_accept();
    expect_resp(0, 2, 2, 16'h3333, 0);

    // R13: write-back and request in the same cycle on the same block
    access(1, 2, 3, '0, 0);
    @(negedge clk);
    wb_valid = 1'b1; wb_src = 2'd2; wb_addr = 3'd3; wb_data = 16'h7E57;
    req_valid = 1'b1; req_wr = 1'b0; req_src = 2'd1; req_addr = 3'd3;
    #1;
    chk(wb_ready && !req_ready, "R13", "write-back taken first", {wb_ready, req_ready}, 2'b10);
    @(posedge clk); #1;
    wb_valid = 1'b0;
    m_mem[3] = 16'h7E57; m_st[3] = 0; m_sh[3] = '0;
    wait_req_accept();
    expect_resp(0, 1, 3, '0, 1);

    // Near-exhaustive mixed traffic against the reference directory
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[1:0] == 2'd3) ref_wb(int'(lfsr[3:2]), int'(lfsr[6:4]), lfsr ^ 16'h5A5A);
      else access(lfsr[0], int'(lfsr[3:2]), int'(lfsr[6:4]), lfsr, int'(lfsr[8:7]));
    end

    report();
    $finish;
  end

endmodule